// File: doc/BRIEF.md
# Wake-Up Release Sequencer

This block runs once a device has finished loading its configuration. It raises four release signals in a fixed pattern over four synchronous phases, T0, T1, T2 and T3, moving one phase per clock. The four signals are: done-flag release, global output-enable release, global write-protect release and global set/reset release. A 5-bit selection input picks the phase in which each signal rises. Each release is sticky, so once raised it stays high until reset. After T3 all four are high.

Start is controlled by a mode input. In the self-start mode the sequence begins as soon as configuration is reported good and the internal done bit is set, whatever level the external done pin shows. In the pin-gated mode the sequencer also waits for the external done pin to read high. That pin is asynchronous, so it first passes through a synchronizer of `SYNC_STAGES` flops.

The controller is a state machine with six states:

| State | Phase code | Role |
|---|---|---|
| `ST_IDLE` | `3'b100` | Waiting for the start condition |
| `ST_T0` | `3'b000` | Phase T0 |
| `ST_T1` | `3'b001` | Phase T1 |
| `ST_T2` | `3'b010` | Phase T2 |
| `ST_T3` | `3'b011` | Phase T3 |
| `ST_WOKE` | `3'b111` | Sequence complete |

Its transitions are:
- IDLE→T0 on the start condition; otherwise IDLE holds.
- T0→T1, T1→T2, T2→T3 and T3→WOKE happen unconditionally.
- WOKE→WOKE until reset.

Top module: `wk_sequencer`

## Requirements
- R1: After reset, `phase_code` is `3'b100` (idle) and all four release outputs are low.
- R2: With `honor_ext`=0, the first rising clock edge that sees `cfg_ok`=1 and `int_done`=1 moves the block to T0. The level of `ext_done_in` has no effect.
- R3: With `honor_ext`=1, the block also needs the synchronized `ext_done_in` to be high, and it stays idle while the pin is low. With `SYNC_STAGES`=2, T0 is entered on the third rising edge after the pin goes high, provided the other start conditions hold.
- R4: While `cfg_ok` is 0 the block stays idle, whatever the other inputs are.
- R5: From T0 the block advances one phase per clock, T0→T1→T2→T3, then moves to complete (`3'b111`) and stays there until reset. `phase_code` shows 0 to 3 during T0 to T3.
- R6: For a selection n from 1 to 24, let m=(n+3) mod 24. Use the digits a=m/6, b=(m/2) mod 3 and c=m mod 2, and start from the ordered free phase list [0,1,2,3]:
  - done takes the free phase at position a;
  - output-enable then takes the free phase at position b;
  - write-protect takes the free phase at position c;
  - set/reset takes the last remaining phase.
  Each taken phase is removed from the list before the next pick.
- R7: Selection 25 releases all four signals together in T3.
- R8: Selections 0 and 26 to 31 act as selection 21. Selection 21 releases done in T0, output-enable in T1, write-protect in T2 and set/reset in T3.
- R9: Each release output never falls before reset, and in the complete state all four are high.
- R10: The selection is captured on the IDLE→T0 edge. Later changes to `seq_sel` do not alter the running sequence.
- R11: A release output rises in the same cycle that `phase_code` first shows the phase assigned to it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_ok | input | 1 | Configuration loaded and checked good |
| int_done | input | 1 | Internal done bit |
| ext_done_in | input | 1 | Level of the external done pin (asynchronous) |
| honor_ext | input | 1 | 1: wait for the external pin; 0: ignore it |
| seq_sel | input | 5 | Release sequence selection |
| rel_done | output | 1 | Done-flag release |
| rel_goe | output | 1 | Global output-enable release |
| rel_gwdis | output | 1 | Global write-protect release |
| rel_gsr | output | 1 | Global set/reset release |
| phase_code | output | 3 | Current state: 0–3 for T0–T3, 4 idle, 7 complete |

## Verification
The assertions check several properties on every cycle:
- the releases are sticky, and all four are high on completion;
- the phase steps by one per clock;
- nothing is released while idle;
- there is no start without `cfg_ok`, and no start in pin-gated mode while the synchronized pin is low;
- every rising release coincides with its latched phase.

Only the bench's scenarios can show the following:
- that the computed selection table matches R6 to R8 for particular indices;
- the exact synchronizer latency of the pin;
- that a change to `seq_sel` in mid-sequence is ignored.

For those, a behavioural model built on a queue-based table derivation is compared with the outputs every clock.

// File: rtl/wk_pkg.sv
package wk_pkg;

    localparam int NUM_REL = 4;   // 0 done, 1 output enable, 2 write protect, 3 set/reset
    localparam int NUM_PH  = 4;
    localparam int PH_W    = $clog2(NUM_PH);
    localparam int NUM_PERM = 24; // orderings of four signals over four phases

    typedef logic [PH_W-1:0] ph_t;
    typedef logic [NUM_REL-1:0][PH_W-1:0] ph_map_t;

    // State encoding doubles as the externally visible phase code.
    typedef enum logic [2:0] {
        ST_T0   = 3'b000,
        ST_T1   = 3'b001,
        ST_T2   = 3'b010,
        ST_T3   = 3'b011,
        ST_IDLE = 3'b100,
        ST_WOKE = 3'b111
    } wk_state_e;

    // Decode a permutation rank into a phase per release signal.
    function automatic ph_map_t rank_to_map(input int unsigned rank);
        ph_map_t           res;
        logic [NUM_PH-1:0] taken;
        int unsigned       digit;
        int unsigned       cnt;
        logic              found;
        res   = '0;
        taken = '0;
        for (int r = 0; r < NUM_REL; r++) begin
            case (r)
                0:       digit = rank / 6;
                1:       digit = (rank / 2) % 3;
                2:       digit = rank % 2;
                default: digit = 0;
            endcase
            cnt   = 0;
            found = 1'b0;
            for (int p = 0; p < NUM_PH; p++) begin
                if (!taken[p] && !found) begin
                    if (cnt == digit) begin
                        res[r]   = PH_W'(p);
                        taken[p] = 1'b1;
                        found    = 1'b1;
                    end else begin
                        cnt = cnt + 1;
                    end
                end
            end
        end
        return res;
    endfunction

endpackage

// File: rtl/wk_seq_decode.sv
module wk_seq_decode
    import wk_pkg::*;
#(
    parameter int SEL_W   = 5,
    parameter int NUM_SEQ = 25,
    parameter int DEF_SEQ = 21
) (
    input  logic [SEL_W-1:0] sel,
    output ph_map_t          map
);

    localparam int RANK_OFS = NUM_PERM - (DEF_SEQ % NUM_PERM); // default maps to rank 0

    always_comb begin
        int unsigned n;
        n = int'(sel);
        if (n == 0 || n > NUM_SEQ) begin
            n = DEF_SEQ;
        end
        if (n == NUM_SEQ) begin
            // last entry: every signal waits for the final phase
            for (int r = 0; r < NUM_REL; r++) begin
                map[r] = PH_W'(NUM_PH - 1);
            end
        end else begin
            map = rank_to_map((n + RANK_OFS) % NUM_PERM);
        end
    end

endmodule

// File: rtl/wk_start_gate.sv
module wk_start_gate #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic cfg_ok,
    input  logic int_done,
    input  logic ext_done_in,
    input  logic honor_ext,
    output logic ext_sync,
    output logic start
);

    logic [SYNC_STAGES-1:0] chain;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            chain <= '0;
        end else begin
            chain[0] <= ext_done_in;
            for (int i = 1; i < SYNC_STAGES; i++) begin
                chain[i] <= chain[i-1];
            end
        end
    end

    assign ext_sync = chain[SYNC_STAGES-1];
    assign start    = cfg_ok & int_done & (~honor_ext | ext_sync);

endmodule

// File: rtl/wk_ctrl.sv
module wk_ctrl
    import wk_pkg::*;
(
    input  logic                clk,
    input  logic                rst_n,
    input  logic                start,
    input  ph_map_t             map_in,
    output wk_state_e           state,
    output logic [NUM_REL-1:0]  rel
);

    wk_state_e            nxt;
    ph_map_t              map_q;
    ph_map_t              use_map;
    logic [NUM_REL-1:0]   rise_mask;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= ST_IDLE;
        end else begin
            state <= nxt;
        end
    end

    always_comb begin
        nxt = state;
        unique case (state)
            ST_IDLE: nxt = start ? ST_T0 : ST_IDLE;
            ST_T0:   nxt = ST_T1;
            ST_T1:   nxt = ST_T2;
            ST_T2:   nxt = ST_T3;
            ST_T3:   nxt = ST_WOKE;
            ST_WOKE: nxt = ST_WOKE;
            default: nxt = ST_IDLE;
        endcase
    end

    // selection is taken live on the start edge, latched afterwards
    assign use_map = (state == ST_IDLE) ? map_in : map_q;

    always_comb begin
        rise_mask = '0;
        for (int r = 0; r < NUM_REL; r++) begin
            if (!nxt[2] && use_map[r] == nxt[1:0]) begin
                rise_mask[r] = 1'b1;
            end
        end
    end

    // outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rel   <= '0;
            map_q <= '0;
        end else begin
            if (state == ST_IDLE && start) begin
                map_q <= map_in;
            end
            rel <= rel | rise_mask;
        end
    end

    // R9
    rel_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rel) & ~rel) == '0);

    // R9
    woke_all_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_WOKE) |-> (rel == '1));

    // R5
    phase_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!state[2] && state != ST_T3) |=> (!state[2] && state[1:0] == $past(state[1:0]) + 2'd1));

    // R5
    last_phase_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_T3) |=> (state == ST_WOKE));

    // R1
    idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IDLE) |-> (rel == '0));

    // R11
    for (genvar r = 0; r < NUM_REL; r++) begin : g_rise
        rise_in_phase_chk: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(rel[r]) |-> (!state[2] && state[1:0] == map_q[r]));
    end

endmodule

// File: rtl/wk_sequencer.sv
module wk_sequencer
    import wk_pkg::*;
#(
    parameter int SEL_W       = 5,
    parameter int NUM_SEQ     = 25,
    parameter int DEF_SEQ     = 21,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cfg_ok,
    input  logic             int_done,
    input  logic             ext_done_in,
    input  logic             honor_ext,
    input  logic [SEL_W-1:0] seq_sel,
    output logic             rel_done,
    output logic             rel_goe,
    output logic             rel_gwdis,
    output logic             rel_gsr,
    output logic [2:0]       phase_code
);

    logic               ext_sync;
    logic               start;
    ph_map_t            sel_map;
    wk_state_e          state;
    logic [NUM_REL-1:0] rel;

    wk_start_gate #(.SYNC_STAGES(SYNC_STAGES)) gate_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .cfg_ok      (cfg_ok),
        .int_done    (int_done),
        .ext_done_in (ext_done_in),
        .honor_ext   (honor_ext),
        .ext_sync    (ext_sync),
        .start       (start)
    );

    wk_seq_decode #(.SEL_W(SEL_W), .NUM_SEQ(NUM_SEQ), .DEF_SEQ(DEF_SEQ)) dec_i (
        .sel (seq_sel),
        .map (sel_map)
    );

    wk_ctrl ctrl_i (
        .clk    (clk),
        .rst_n  (rst_n),
        .start  (start),
        .map_in (sel_map),
        .state  (state),
        .rel    (rel)
    );

    assign rel_done   = rel[0];
    assign rel_goe    = rel[1];
    assign rel_gwdis  = rel[2];
    assign rel_gsr    = rel[3];
    assign phase_code = state;

    // R4
    no_cfg_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (phase_code == ST_IDLE && !cfg_ok) |=> (phase_code == ST_IDLE));

    // R3
    pin_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (phase_code == ST_IDLE && honor_ext && !ext_sync) |=> (phase_code == ST_IDLE));

endmodule

// File: tb/wk_sequencer_tb.sv
`timescale 1ns/1ps
module wk_sequencer_tb_top;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cfg_ok = 1'b0;
    logic       int_done = 1'b0;
    logic       ext_done_in = 1'b0;
    logic       honor_ext = 1'b0;
    logic [4:0] seq_sel = 5'd21;
    logic       rel_done, rel_goe, rel_gwdis, rel_gsr;
    logic [2:0] phase_code;

    int checks = 0;
    int failures = 0;
    bit cmp_en = 1'b0;
    bit finished = 1'b0;
    string tag = "R1";

    always #10 clk = ~clk;

    wk_sequencer dut_i (
        .clk(clk), .rst_n(rst_n), .cfg_ok(cfg_ok), .int_done(int_done),
        .ext_done_in(ext_done_in), .honor_ext(honor_ext), .seq_sel(seq_sel),
        .rel_done(rel_done), .rel_goe(rel_goe), .rel_gwdis(rel_gwdis),
        .rel_gsr(rel_gsr), .phase_code(phase_code)
    );

    // ---------------- reference model ----------------
    int m_st = -1;          // -1 idle, 0..3 phase, 4 complete
    int m_ph[4];
    bit [3:0] m_rel = '0;
    bit hist[$];

    function automatic void build_map(input int sel);
        int n;
        int q[$];
        int rank;
        int dig[3];
        n = sel;
        if (n == 0 || n > 25) n = 21;
        if (n == 25) begin
            foreach (m_ph[i]) m_ph[i] = 3;
            return;
        end
        rank = (n + 3) % 24;
        dig[0] = rank / 6;
        dig[1] = (rank / 2) % 3;
        dig[2] = rank % 2;
        q = '{0, 1, 2, 3};
        for (int i = 0; i < 3; i++) begin
            m_ph[i] = q[dig[i]];
            q.delete(dig[i]);
        end
        m_ph[3] = q[0];
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            m_st = -1;
            m_rel = '0;
            hist = '{1'b0, 1'b0};
        end else begin
            bit synced;
            synced = hist[0];
            void'(hist.pop_front());
            hist.push_back(ext_done_in);
            if (m_st == -1) begin
                if (cfg_ok && int_done && (!honor_ext || synced)) begin
                    build_map(int'(seq_sel));
                    m_st = 0;
                end
            end else if (m_st < 4) begin
                m_st++;
            end
            if (m_st >= 0 && m_st <= 3) begin
                for (int r = 0; r < 4; r++) if (m_ph[r] == m_st) m_rel[r] = 1'b1;
            end
        end
    end

    function automatic int exp_code();
        if (m_st < 0) return 4;
        if (m_st > 3) return 7;
        return m_st;
    endfunction

    task automatic check(input string req, input int act, input int exp, input string what);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    always @(negedge clk) begin
        if (cmp_en && !finished) begin
            check(tag, int'(phase_code), exp_code(), "phase_code");
            check(tag, int'({rel_gsr, rel_gwdis, rel_goe, rel_done}), int'(m_rel), "releases");
        end
    end

    // ---------------- stimulus ----------------
    task automatic do_reset();
        cmp_en = 1'b0;
        cfg_ok = 1'b0; int_done = 1'b0; ext_done_in = 1'b0;
        @(negedge clk);
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        cmp_en = 1'b1;
    endtask

    task automatic wait_woke();
        for (int i = 0; i < 20; i++) begin
            if (phase_code == 3'b111) break;
            @(negedge clk);
        end
    endtask

    task automatic run_sel(input int sel, input string req);
        do_reset();
        tag = req;
        honor_ext = 1'b0;
        seq_sel = 5'(sel);
        cfg_ok = 1'b1; int_done = 1'b1;
        @(negedge clk);
        check(req, int'(phase_code), 0, "entered T0");
        wait_woke();
        check("R9", int'({rel_gsr, rel_gwdis, rel_goe, rel_done}), 15, "all released");
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        cmp_en = 1'b1;
        // R1 reset state
        check("R1", int'(phase_code), 4, "reset phase");
        check("R1", int'({rel_gsr, rel_gwdis, rel_goe, rel_done}), 0, "reset releases");

        // R4 no start without configuration good
        tag = "R4";
        int_done = 1'b1; ext_done_in = 1'b1;
        repeat (5) @(negedge clk);
        check("R4", int'(phase_code), 4, "idle without cfg_ok");

        // R2 self-start ignoring a low pin, default table entry R8
        do_reset();
        tag = "R2";
        honor_ext = 1'b0; ext_done_in = 1'b0; seq_sel = 5'd21;
        cfg_ok = 1'b1; int_done = 1'b1;
        @(negedge clk);
        check("R2", int'(phase_code), 0, "start with pin low");
        check("R11", int'({rel_gsr, rel_gwdis, rel_goe, rel_done}), 1, "done rises with T0");
        @(negedge clk);
        check("R8", int'({rel_gsr, rel_gwdis, rel_goe, rel_done}), 3, "goe in T1");
        wait_woke();
        repeat (3) @(negedge clk);
        check("R5", int'(phase_code), 7, "complete holds");
        check("R9", int'({rel_gsr, rel_gwdis, rel_goe, rel_done}), 15, "sticky releases");

        // R3 pin-gated start
        do_reset();
        tag = "R3";
        honor_ext = 1'b1; seq_sel = 5'd5;
        cfg_ok = 1'b1; int_done = 1'b1; ext_done_in = 1'b0;
        repeat (6) @(negedge clk);
        check("R3", int'(phase_code), 4, "waits for pin");
        ext_done_in = 1'b1;
        repeat (2) @(negedge clk);
        check("R3", int'(phase_code), 4, "synchronizer latency");
        @(negedge clk);
        check("R3", int'(phase_code), 0, "start after pin high");
        wait_woke();

        // R8 out-of-range and zero selections
        run_sel(0, "R8");
        run_sel(26, "R8");
        run_sel(31, "R8");
        // R6 permutation entries
        run_sel(1, "R6");
        run_sel(13, "R6");
        run_sel(24, "R6");

        // R6 explicit: selection 1 puts write protect in T1, output enable in T3
        do_reset();
        tag = "R6";
        honor_ext = 1'b0; seq_sel = 5'd1; cfg_ok = 1'b1; int_done = 1'b1;
        repeat (2) @(negedge clk);
        check("R6", int'({rel_gsr, rel_gwdis, rel_goe, rel_done}), 5, "sel 1 at T1");
        wait_woke();

        // R7 all released together in T3
        do_reset();
        tag = "R7";
        seq_sel = 5'd25; cfg_ok = 1'b1; int_done = 1'b1;
        repeat (3) @(negedge clk);
        check("R7", int'({rel_gsr, rel_gwdis, rel_goe, rel_done}), 0, "nothing by T2");
        @(negedge clk);
        check("R7", int'({rel_gsr, rel_gwdis, rel_goe, rel_done}), 15, "all at T3");
        wait_woke();

        // R10 selection change mid-sequence is ignored
        do_reset();
        tag = "R10";
        seq_sel = 5'd21; cfg_ok = 1'b1; int_done = 1'b1;
        @(negedge clk);
        seq_sel = 5'd25;
        @(negedge clk);
        check("R10", int'(rel_goe), 1, "latched selection kept");
        wait_woke();

        finished = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            checks++;
            failures++;
            $display("FAIL R5 watchdog actual=hung expected=complete");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

endmodule